// File: doc/BRIEF.md
# AND-Test Flag Unit with Carry-Producing Shifter

This block computes the condition flags for a bit-test operation. The second operand goes through a barrel shifter, chosen by a 2-bit shift kind and a 5-bit immediate amount. The shifted value is ANDed with the first operand. The AND value itself is thrown away. Only the negative (N), zero (Z) and carry (C) flags are written into a registered NZCV word, and the overflow flag (V) keeps its value. The C flag is the carry that leaves the shifter, not an adder carry. A shift into C reads the registered C flag as its carry input.

Operations enter on a valid/ready port. `op_ready` is always high, so the unit never applies back-pressure. An operation is accepted in every cycle in which `op_valid` is high. It changes the flags only if `cond_pass` is high in the same cycle. Each update takes exactly one clock, whatever the operand or flag values. A separate preset port writes all four flags at once, for flag writes that come from outside this unit. The preset takes priority over an operation in the same cycle.

Top module: `andtest_flag_unit`

## Requirements
- R1: While `rst_n` is low, and in the first cycle after it is released, `nzcv_q` is 4'b0000. The bit order is N=bit 3, Z=bit 2, C=bit 1, V=bit 0.
- R2: Kind 2'b00 is a left shift by the amount field (0 to 31). For an amount of 0 the operand passes unchanged and the carry is the current C. For an amount n of 1 to 31 the carry is operand bit 32-n.
- R3: Kind 2'b01 is a logical right shift. An amount field of 0 means a shift by 32. For a shift by n, the carry is operand bit n-1. A shift by 32 gives a zero value with carry equal to bit 31.
- R4: Kind 2'b10 is an arithmetic right shift. The vacated bits are filled with bit 31. An amount field of 0 means a shift by 32, which fills every bit with bit 31 and gives carry equal to bit 31. Otherwise the carry is bit n-1.
- R5: Kind 2'b11 with an amount n of 1 to 31 rotates right by n. The carry is bit 31 of the rotated value.
- R6: Kind 2'b11 with an amount field of 0 is a one-bit rotate through carry. The current C enters bit 31, and the original bit 0 becomes the carry.
- R7: After an operation, N equals bit 31 of (A AND shifted B), and Z is 1 exactly when that AND value is all zeros.
- R8: An operation never changes V.
- R9: If `op_valid` or `cond_pass` is low and `flags_ld` is low, all four flags keep their values.
- R10: When `flags_ld` is high, `nzcv_q` takes `flags_ld_val` on the next edge, even if an operation is accepted in the same cycle.
- R11: `op_ready` is always high. An accepted operation changes the flags on the next rising edge and not before, back to back, with the same latency for every operand and flag value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| op_valid | input | 1 | Operation present |
| op_ready | output | 1 | Always 1; no back-pressure |
| cond_pass | input | 1 | Operation's condition passed; gates the flag update |
| opnd_a | input | 32 | First operand |
| opnd_b | input | 32 | Operand that is shifted |
| sh_kind | input | 2 | 00 left, 01 logical right, 10 arithmetic right, 11 rotate |
| sh_field | input | 5 | Immediate shift amount field |
| flags_ld | input | 1 | Preset strobe for the flags |
| flags_ld_val | input | 4 | Preset value, NZCV order |
| nzcv_q | output | 4 | Registered flags {N,Z,C,V} |

## Verification
The assertions assume two things about the inputs. First, `op_valid`, `cond_pass`, `flags_ld` and the operand fields are stable across each rising edge. Second, a preset and an operation may meet in the same cycle, so each property that checks operation behaviour excludes the preset cycle. The bench drives every input on the falling edge, so values are settled well before the sampling edge. It keeps a separate bit-by-bit reference model of the flags, which also covers the cycles where a preset and an operation collide. Operands come from fixed patterns and a small congruential sequence that walks through every shift kind and every amount field.

// File: rtl/andtest_pkg.sv
package andtest_pkg;
  typedef enum logic [2:0] {
    SOP_LSL = 3'd0,
    SOP_LSR = 3'd1,
    SOP_ASR = 3'd2,
    SOP_ROR = 3'd3,
    SOP_RRX = 3'd4
  } shift_op_e;

  localparam int unsigned FLAG_N = 3;
  localparam int unsigned FLAG_Z = 2;
  localparam int unsigned FLAG_C = 1;
  localparam int unsigned FLAG_V = 0;
  localparam int unsigned FLAG_W = 4;
endpackage

// File: rtl/andtest_shamt_decode.sv
module andtest_shamt_decode
  import andtest_pkg::*;
#(
  parameter int unsigned W = 32,
  localparam int unsigned FW = $clog2(W),
  localparam int unsigned AW = FW + 1
) (
  input  logic [1:0]    kind,
  input  logic [FW-1:0] field,
  output shift_op_e     op,
  output logic [AW-1:0] amt
);
  localparam logic [AW-1:0] FULL = AW'(W);

  logic field_zero;
  assign field_zero = (field == '0);

  always_comb begin
    op  = SOP_LSL;
    amt = {1'b0, field};
    unique case (kind)
      2'b00: begin
        op  = SOP_LSL;
        amt = {1'b0, field};
      end
      2'b01: begin
        op  = SOP_LSR;
        amt = field_zero ? FULL : {1'b0, field};
      end
      2'b10: begin
        op  = SOP_ASR;
        amt = field_zero ? FULL : {1'b0, field};
      end
      default: begin
        op  = field_zero ? SOP_RRX : SOP_ROR;
        amt = field_zero ? AW'(1) : {1'b0, field};
      end
    endcase
  end
endmodule

// File: rtl/andtest_carry_shifter.sv
module andtest_carry_shifter
  import andtest_pkg::*;
#(
  parameter int unsigned W = 32,
  localparam int unsigned AW = $clog2(W) + 1
) (
  input  logic [W-1:0]  din,
  input  shift_op_e     op,
  input  logic [AW-1:0] amt,
  input  logic          cin,
  output logic [W-1:0]  dout,
  output logic          cout
);
  localparam logic [AW-1:0] FULL = AW'(W);

  logic [W:0]    ext_l;
  logic [W:0]    ext_r;
  logic [W:0]    ext_a;
  logic [W-1:0]  rot;
  logic [AW-1:0] back;

  assign back  = FULL - amt;
  assign ext_l = {1'b0, din} << amt;
  assign ext_r = {din, 1'b0} >> amt;
  assign ext_a = $unsigned($signed({din, 1'b0}) >>> amt);
  assign rot   = (din >> amt) | (din << back);

  always_comb begin
    dout = din;
    cout = cin;
    unique case (op)
      SOP_LSL: begin
        if (amt != '0) begin
          dout = ext_l[W-1:0];
          cout = ext_l[W];
        end
      end
      SOP_LSR: begin
        dout = ext_r[W:1];
        cout = ext_r[0];
      end
      SOP_ASR: begin
        dout = ext_a[W:1];
        cout = ext_a[0];
      end
      SOP_ROR: begin
        dout = rot;
        cout = rot[W-1];
      end
      default: begin
        dout = {cin, din[W-1:1]};
        cout = din[0];
      end
    endcase
  end
endmodule

// File: rtl/andtest_flag_gen.sv
module andtest_flag_gen #(
  parameter int unsigned W = 32
) (
  input  logic [W-1:0] opa,
  input  logic [W-1:0] opb_sh,
  output logic         neg,
  output logic         zero
);
  logic [W-1:0] masked;
  assign masked = opa & opb_sh;
  assign neg    = masked[W-1];
  assign zero   = ~|masked;
endmodule

// File: rtl/andtest_flag_unit.sv
module andtest_flag_unit
  import andtest_pkg::*;
#(
  parameter int unsigned W = 32,
  localparam int unsigned FW = $clog2(W),
  localparam int unsigned AW = FW + 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          op_valid,
  output logic          op_ready,
  input  logic          cond_pass,
  input  logic [W-1:0]  opnd_a,
  input  logic [W-1:0]  opnd_b,
  input  logic [1:0]    sh_kind,
  input  logic [FW-1:0] sh_field,
  input  logic          flags_ld,
  input  logic [3:0]    flags_ld_val,
  output logic [3:0]    nzcv_q
);
  shift_op_e     dec_op;
  logic [AW-1:0] dec_amt;
  logic [W-1:0]  b_sh;
  logic          sh_carry;
  logic          f_neg;
  logic          f_zero;
  logic          upd;
  logic [3:0]    nzcv_d;

  assign op_ready = 1'b1;
  assign upd      = op_valid & op_ready & cond_pass;

  andtest_shamt_decode #(.W(W)) u_dec (
    .kind  (sh_kind),
    .field (sh_field),
    .op    (dec_op),
    .amt   (dec_amt)
  );

  andtest_carry_shifter #(.W(W)) u_shf (
    .din  (opnd_b),
    .op   (dec_op),
    .amt  (dec_amt),
    .cin  (nzcv_q[FLAG_C]),
    .dout (b_sh),
    .cout (sh_carry)
  );

  andtest_flag_gen #(.W(W)) u_flg (
    .opa    (opnd_a),
    .opb_sh (b_sh),
    .neg    (f_neg),
    .zero   (f_zero)
  );

  always_comb begin
    nzcv_d = nzcv_q;
    if (flags_ld) begin
      nzcv_d = flags_ld_val;
    end else if (upd) begin
      nzcv_d[FLAG_N] = f_neg;
      nzcv_d[FLAG_Z] = f_zero;
      nzcv_d[FLAG_C] = sh_carry;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) nzcv_q <= '0;
    else        nzcv_q <= nzcv_d;
  end
endmodule

// File: rtl/andtest_flag_chk.sv
module andtest_flag_chk #(
  parameter int unsigned W = 32,
  localparam int unsigned FW = $clog2(W)
) (
  input logic          clk,
  input logic          rst_n,
  input logic          op_valid,
  input logic          op_ready,
  input logic          cond_pass,
  input logic [W-1:0]  opnd_a,
  input logic [W-1:0]  opnd_b,
  input logic [1:0]    sh_kind,
  input logic [FW-1:0] sh_field,
  input logic          flags_ld,
  input logic [3:0]    flags_ld_val,
  input logic [3:0]    nzcv_q
);
  logic fire;
  assign fire = op_valid && op_ready && cond_pass && !flags_ld;

  // R9
  hold_when_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!flags_ld && !(op_valid && cond_pass)) |=> $stable(nzcv_q));

  // R8
  v_untouched_chk: assert property (@(posedge clk) disable iff (!rst_n)
    fire |=> (nzcv_q[0] == $past(nzcv_q[0])));

  // R10
  preset_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
    flags_ld |=> (nzcv_q == $past(flags_ld_val)));

  // R7
  n_z_exclusive_chk: assert property (@(posedge clk) disable iff (!rst_n)
    fire |=> !(nzcv_q[3] && nzcv_q[2]));

  // R2
  lsl_zero_pass_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (fire && sh_kind == 2'b00 && sh_field == '0) |=>
      (nzcv_q[3] == $past(opnd_a[W-1] & opnd_b[W-1]) &&
       nzcv_q[2] == ($past(opnd_a & opnd_b) == '0) &&
       nzcv_q[1] == $past(nzcv_q[1])));

  // R3
  lsr_full_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (fire && sh_kind == 2'b01 && sh_field == '0) |=>
      (nzcv_q[3:1] == {2'b01, $past(opnd_b[W-1])}));

  // R6
  rrx_carry_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (fire && sh_kind == 2'b11 && sh_field == '0) |=>
      (nzcv_q[1] == $past(opnd_b[0])));

  // R11
  always_comb begin
    if (rst_n) ready_high_chk: assert (op_ready);
  end
endmodule

bind andtest_flag_unit andtest_flag_chk #(.W(W)) u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .op_valid     (op_valid),
  .op_ready     (op_ready),
  .cond_pass    (cond_pass),
  .opnd_a       (opnd_a),
  .opnd_b       (opnd_b),
  .sh_kind      (sh_kind),
  .sh_field     (sh_field),
  .flags_ld     (flags_ld),
  .flags_ld_val (flags_ld_val),
  .nzcv_q       (nzcv_q)
);

// File: tb/sim_andtest_flag_unit.sv
module sim_andtest_flag_unit;
  localparam int CLK_PERIOD = 10;
  localparam int WATCHDOG   = 20000;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        op_valid = 1'b0;
  logic        op_ready;
  logic        cond_pass = 1'b0;
  logic [31:0] opnd_a = '0;
  logic [31:0] opnd_b = '0;
  logic [1:0]  sh_kind = '0;
  logic [4:0]  sh_field = '0;
  logic        flags_ld = 1'b0;
  logic [3:0]  flags_ld_val = '0;
  logic [3:0]  nzcv_q;

  int checks = 0;
  int errors = 0;
  logic [3:0] model = 4'b0000;
  logic [31:0] lcg = 32'h1234_5678;

  always #(CLK_PERIOD/2) clk = ~clk;

  andtest_flag_unit u0 (
    .clk(clk), .rst_n(rst_n), .op_valid(op_valid), .op_ready(op_ready),
    .cond_pass(cond_pass), .opnd_a(opnd_a), .opnd_b(opnd_b),
    .sh_kind(sh_kind), .sh_field(sh_field), .flags_ld(flags_ld),
    .flags_ld_val(flags_ld_val), .nzcv_q(nzcv_q)
  );

  function automatic logic [3:0] ref_nzcv(input logic [31:0] a, input logic [31:0] b,
                                          input logic [1:0] k, input logic [4:0] f,
                                          input logic [3:0] cur);
    logic [31:0] s;
    logic [31:0] r;
    logic c;
    int n;
    n = int'(f);
    s = '0;
    c = cur[1];
    case (k)
      2'b00: begin
        for (int i = 0; i < 32; i++) s[i] = (i - n >= 0) ? b[i - n] : 1'b0;
        c = (n == 0) ? cur[1] : b[32 - n];
      end
      2'b01: begin
        if (n == 0) n = 32;
        for (int i = 0; i < 32; i++) s[i] = (i + n < 32) ? b[i + n] : 1'b0;
        c = b[n - 1];
      end
      2'b10: begin
        if (n == 0) n = 32;
        for (int i = 0; i < 32; i++) s[i] = (i + n < 32) ? b[i + n] : b[31];
        c = b[n - 1];
      end
      default: begin
        if (n == 0) begin
          for (int i = 0; i < 32; i++) s[i] = (i == 31) ? cur[1] : b[i + 1];
          c = b[0];
        end else begin
          for (int i = 0; i < 32; i++) s[i] = b[(i + n) % 32];
          c = s[31];
        end
      end
    endcase
    r = a & s;
    return {r[31], (r == 32'd0), c, cur[0]};
  endfunction

  task automatic check(input string req, input logic [3:0] got, input logic [3:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s got %b expected %b", req, got, exp);
    end
  endtask

  // Drive one cycle at negedge, clock it, sample at next negedge.
  task automatic cycle(input logic [31:0] a, input logic [31:0] b, input logic [1:0] k,
                       input logic [4:0] f, input logic v, input logic cp,
                       input logic ld, input logic [3:0] ldv);
    opnd_a = a; opnd_b = b; sh_kind = k; sh_field = f;
    op_valid = v; cond_pass = cp; flags_ld = ld; flags_ld_val = ldv;
    #1;
    check("R11 no early change", nzcv_q, model);
    if (ld) model = ldv;
    else if (v && cp) model = ref_nzcv(a, b, k, f, model);
    @(posedge clk);
    @(negedge clk);
    op_valid = 1'b0; cond_pass = 1'b0; flags_ld = 1'b0;
  endtask

  task automatic preset(input logic [3:0] val);
    cycle('0, '0, 2'b00, 5'd0, 1'b0, 1'b0, 1'b1, val);
    check("R10 preset", nzcv_q, val);
  endtask

  task automatic run_op(input string req, input logic [31:0] a, input logic [31:0] b,
                        input logic [1:0] k, input logic [4:0] f);
    cycle(a, b, k, f, 1'b1, 1'b1, 1'b0, 4'b0);
    check(req, nzcv_q, model);
  endtask

  task automatic t_reset();
    check("R1 reset", nzcv_q, 4'b0000);
    checks++;
    if (op_ready !== 1'b1) begin errors++; $display("FAIL R11 ready got %b expected 1", op_ready); end
  endtask

  task automatic t_lsl();
    preset(4'b0010);
    run_op("R2 lsl0 carry kept", 32'hFFFF_FFFF, 32'h8000_0001, 2'b00, 5'd0);
    check("R2 lsl0 value", nzcv_q, 4'b1010);
    run_op("R2 lsl1", 32'hFFFF_FFFF, 32'h8000_0000, 2'b00, 5'd1);
    check("R2 lsl1 carry bit31", nzcv_q, 4'b0110);
    run_op("R2 lsl31", 32'h8000_0000, 32'h0000_0003, 2'b00, 5'd31);
    check("R2 lsl31", nzcv_q, 4'b1010);
  endtask

  task automatic t_lsr();
    preset(4'b0000);
    run_op("R3 lsr4", 32'hFFFF_FFFF, 32'h0000_0018, 2'b01, 5'd4);
    check("R3 lsr4 carry bit3", nzcv_q, 4'b0010);
    run_op("R3 lsr32", 32'hFFFF_FFFF, 32'h8000_0000, 2'b01, 5'd0);
    check("R3 lsr32", nzcv_q, 4'b0110);
  endtask

  task automatic t_asr();
    preset(4'b0000);
    run_op("R4 asr32 neg", 32'h8000_0000, 32'h8000_0000, 2'b10, 5'd0);
    check("R4 asr32 neg", nzcv_q, 4'b1010);
    run_op("R4 asr31", 32'h0000_0001, 32'h4000_0000, 2'b10, 5'd31);
    check("R4 asr31 carry bit30", nzcv_q, 4'b0110);
  endtask

  task automatic t_ror();
    preset(4'b0000);
    run_op("R5 ror8", 32'hFF00_0000, 32'h0000_0080, 2'b11, 5'd8);
    check("R5 ror8", nzcv_q, 4'b1010);
  endtask

  task automatic t_rrx();
    preset(4'b0010);
    run_op("R6 rrx cin1", 32'h8000_0000, 32'h0000_0000, 2'b11, 5'd0);
    check("R6 rrx cin1", nzcv_q, 4'b1000);
    run_op("R6 rrx cin0", 32'hFFFF_FFFF, 32'h0000_0001, 2'b11, 5'd0);
    check("R6 rrx cin0", nzcv_q, 4'b0110);
  endtask

  task automatic t_v_hold();
    preset(4'b0001);
    run_op("R8 v kept", 32'h0000_0F00, 32'h0000_0F00, 2'b00, 5'd0);
    check("R8 v kept R7 nonzero", nzcv_q, 4'b0001);
  endtask

  task automatic t_gated();
    preset(4'b1011);
    cycle(32'h0, 32'h0, 2'b00, 5'd0, 1'b1, 1'b0, 1'b0, 4'b0);
    check("R9 cond low", nzcv_q, 4'b1011);
    cycle(32'h0, 32'h0, 2'b00, 5'd0, 1'b0, 1'b1, 1'b0, 4'b0);
    check("R9 valid low", nzcv_q, 4'b1011);
  endtask

  task automatic t_collide();
    preset(4'b0000);
    cycle(32'hFFFF_FFFF, 32'hFFFF_FFFF, 2'b00, 5'd0, 1'b1, 1'b1, 1'b1, 4'b0101);
    check("R10 preset wins", nzcv_q, 4'b0101);
  endtask

  task automatic t_sweep();
    preset(4'b0110);
    for (int k = 0; k < 4; k++) begin
      for (int f = 0; f < 32; f++) begin
        logic [31:0] a;
        logic [31:0] b;
        lcg = lcg * 32'd1664525 + 32'd1013904223;
        b = lcg;
        lcg = lcg * 32'd1664525 + 32'd1013904223;
        a = (f % 3 == 0) ? 32'hFFFF_FFFF : lcg;
        case (k)
          0: run_op("R2 R7 sweep lsl", a, b, 2'(k), 5'(f));
          1: run_op("R3 R7 sweep lsr", a, b, 2'(k), 5'(f));
          2: run_op("R4 R7 sweep asr", a, b, 2'(k), 5'(f));
          default: run_op("R5 R6 R7 sweep ror", a, b, 2'(k), 5'(f));
        endcase
      end
    end
  endtask

  initial begin
    repeat (WATCHDOG) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    check("R1 in reset", nzcv_q, 4'b0000);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_lsl();
    t_lsr();
    t_asr();
    t_ror();
    t_rrx();
    t_v_hold();
    t_gated();
    t_collide();
    t_sweep();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule